// File: doc/BRIEF.md
# Dual-Fetch Single-Dispatch Instruction Queue

This block sits between an instruction fetch unit and a decode stage. On each clock, fetch may offer zero, one or two instruction words. The queue takes as many as it has room for and appends them in program order. From its head it hands at most one word per clock to decode, and only when decode signals that it is ready. Every word reaches decode through the head of the queue; a word written in a cycle is never passed straight through in that same cycle.

Because fetch can supply twice what decode consumes, the queue normally runs saturated at its full six entries. Its occupancy falls only when fetch stops delivering, for example during a cache miss. Fetch is told how many words it may present this cycle. That figure counts the slot freed by a dispatch in the same cycle, so a full queue whose head is leaving still takes one word. A flush input empties the queue in one cycle and discards any words offered alongside it.

Top module: `instr_queue`

## Requirements
- R1: After reset, occupancy is 0, out_valid is 0 and accept is 2.
- R2: When two words are taken in one cycle, the word on in_data0 is dispatched before the word on in_data1, and all words leave in the order they arrived.
- R3: out_valid is 1 exactly when occupancy is nonzero. A dispatch (one word) occurs in a cycle where out_valid and out_ready are both 1. While the head is not dispatched, out_data holds its value.
- R4: Without flush, occupancy at the next edge equals occupancy + words taken − dispatched (0 or 1).
- R5: accept (0, 1 or 2) equals the smaller of 2 and DEPTH − occupancy + (1 if a dispatch occurs this cycle, else 0).
- R6: Occupancy never exceeds DEPTH (6). A full queue with out_ready low reports accept 0.
- R7: Flush makes occupancy 0 at the next edge, whatever in_cnt and out_ready are in that cycle.
- R8: A word written into an empty queue is not visible in the cycle it is offered: out_valid stays 0 until the following cycle.
- R9: If in_cnt exceeds accept, only the first accept words (in_data0, then in_data1) are taken and the rest are ignored.
- R10: With two words offered and out_ready high every cycle, a full queue stays at occupancy 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all queued words and words offered this cycle |
| in_cnt | input | 2 | Number of words fetch offers this cycle (0 to 2) |
| in_data0 | input | W | Older offered word |
| in_data1 | input | W | Younger offered word |
| accept | output | 2 | Number of words the queue takes this cycle |
| out_valid | output | 1 | Head word present for decode |
| out_data | output | W | Head word |
| out_ready | input | 1 | Decode takes the head this cycle |
| occupancy | output | $clog2(DEPTH+1) | Words currently held |

## Verification
Insertion and dispatch fall in the same cycle whenever the queue is non-empty, out_ready is high and fetch offers words. The hardest case is a full queue, where the one slot being freed must be offered back to fetch at once. The bench drives that case and the near-full cases (four and five entries with two offered). It judges the accept count it sees before the edge and the occupancy after the edge against a table. Every dispatched word is compared against a program-order model, so a lost or reordered word is caught. Flush is also raised together with an insert and a dispatch, and the result must be empty.

// File: rtl/instr_queue.sv
module instr_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [1:0]    in_cnt,
  input  logic [W-1:0]  in_data0,
  input  logic [W-1:0]  in_data1,
  output logic [1:0]    accept,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          out_ready,
  output logic [CW-1:0] occupancy
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;
  logic          pop;
  logic [CW:0]   room;
  logic [1:0]    take;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop       = (count != '0) && out_ready;
  assign room      = (CW+1)'(DEPTH) - {1'b0, count} + {{CW{1'b0}}, pop};
  assign accept    = (room >= (CW+1)'(2)) ? 2'd2 : room[1:0];
  assign take      = (in_cnt > accept) ? accept : in_cnt;
  assign out_valid = (count != '0);
  assign out_data  = slot[head];
  assign occupancy = count;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (pop) head <= step(head);
      if (take == 2'd1) tail <= step(tail);
      else if (take == 2'd2) tail <= step(step(tail));
      count <= count + CW'(take) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush) begin
      if (take != 2'd0) slot[tail] <= in_data0;
      if (take == 2'd2) slot[step(tail)] <= in_data1;
    end
  end
endmodule

module instr_queue_chk #(
  parameter int W     = 32,
  parameter int DEPTH = 6,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic [1:0]    in_cnt,
  input logic [1:0]    accept,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic          out_ready,
  input logic [CW-1:0] occupancy
);
  logic [1:0] taken;
  assign taken = (in_cnt > accept) ? accept : in_cnt;

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CW'(DEPTH));
  a_r6_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == CW'(DEPTH) && !out_ready) |-> accept == 2'd0);
  a_r4_count: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> occupancy == $past(occupancy) + CW'($past(taken))
                           - CW'($past(out_valid && out_ready)));
  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occupancy == '0);
  a_r8_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |-> !out_valid);
  a_r3_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));
  a_r5_accept_range: assert property (@(posedge clk) disable iff (!rst_n)
    accept <= 2'd2);
endmodule

bind instr_queue instr_queue_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_cnt(in_cnt), .accept(accept),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
  .occupancy(occupancy));

// File: tb/test_instr_queue.sv
module test_instr_queue;
  localparam int W = 32;
  localparam int DEPTH = 6;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, flush = 0, out_ready = 0;
  logic [1:0] in_cnt = 0;
  logic [W-1:0] in_data0 = 0, in_data1 = 0, out_data;
  logic [1:0] accept;
  logic out_valid;
  logic [CW-1:0] occupancy;

  always #2 clk = ~clk;

  instr_queue #(.W(W), .DEPTH(DEPTH)) i_instr_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_cnt(in_cnt),
    .in_data0(in_data0), .in_data1(in_data1), .accept(accept),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .occupancy(occupancy));

  int checks = 0, fails = 0;
  int unsigned model[$];
  int unsigned serial = 100;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flush, in_cnt, out_ready, expected accept, expected occupancy after edge
  typedef struct packed {
    logic fl; logic [1:0] n; logic rdy; logic [1:0] acc; logic [3:0] occ;
  } vec_t;
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd2, 1'b0, 2'd2, 4'd2},
    '{1'b0, 2'd2, 1'b0, 2'd2, 4'd4},
    '{1'b0, 2'd2, 1'b1, 2'd2, 4'd5},
    '{1'b0, 2'd2, 1'b0, 2'd1, 4'd6},
    '{1'b0, 2'd2, 1'b0, 2'd0, 4'd6},
    '{1'b0, 2'd2, 1'b1, 2'd1, 4'd6},
    '{1'b0, 2'd0, 1'b1, 2'd1, 4'd5},
    '{1'b0, 2'd0, 1'b1, 2'd2, 4'd4},
    '{1'b0, 2'd1, 1'b1, 2'd2, 4'd4},
    '{1'b1, 2'd2, 1'b1, 2'd2, 4'd0},
    '{1'b0, 2'd1, 1'b1, 2'd2, 4'd1},
    '{1'b0, 2'd0, 1'b1, 2'd2, 4'd0},
    '{1'b0, 2'd0, 1'b1, 2'd2, 4'd0}
  };

  // drive at negedge, check combinational outputs, step one edge, update model
  task automatic cycle(input logic fl, input logic [1:0] n, input logic rdy,
                       input int exp_acc, input string tag);
    int take;
    @(negedge clk);
    flush = fl; in_cnt = n; out_ready = rdy;
    in_data0 = serial; in_data1 = serial + 1;
    #1;
    if (exp_acc >= 0) chk({tag, " R5 accept"}, accept, exp_acc);
    chk("R3 out_valid", out_valid, model.size() != 0);
    if (out_valid && rdy && model.size() != 0)
      chk("R2 order", out_data, model[0]);
    take = (n > accept) ? accept : n;
    @(posedge clk);
    if (model.size() != 0 && rdy) void'(model.pop_front());
    if (fl) model.delete();
    else begin
      if (take >= 1) model.push_back(serial);
      if (take == 2) model.push_back(serial + 1);
    end
    serial += 2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 occupancy", occupancy, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 accept", accept, 2);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      cycle(VEC[i].fl, VEC[i].n, VEC[i].rdy, VEC[i].acc, "R9");
      #1;
      chk(VEC[i].fl ? "R7 flush" : "R4 occupancy", occupancy, VEC[i].occ);
    end

    // R6: fill and hold without dispatch
    for (int i = 0; i < 4; i++) cycle(1'b0, 2'd2, 1'b0, -1, "R6");
    #1; chk("R6 capacity", occupancy, DEPTH);
    cycle(1'b0, 2'd2, 1'b0, 0, "R6");

    // R10: steady state under full fetch and full decode
    for (int i = 0; i < 20; i++) begin
      cycle(1'b0, 2'd2, 1'b1, 1, "R10");
      #1; chk("R10 steady", occupancy, DEPTH);
    end

    // R8: no pass-through on an empty queue
    cycle(1'b1, 2'd0, 1'b0, -1, "R7");
    @(negedge clk);
    in_cnt = 1; in_data0 = 32'hABCD; out_ready = 1; flush = 0;
    #1; chk("R8 no bypass valid", out_valid, 0);
    @(posedge clk); #1;
    chk("R8 visible next", out_valid, 1);
    chk("R8 head data", out_data, 32'hABCD);
    @(negedge clk); in_cnt = 0;
    @(posedge clk); #1;
    chk("R3 single dispatch empties", occupancy, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule